// File: doc/BRIEF.md
# PCM Transmit Serial Port

This block takes 8-bit sign-magnitude sample codes from an encoder and sends them out one bit at a time on a serial data pin. All activity runs on one fast system clock. The serial data clock, the data enable and the frame sync arrive as plain level inputs that are sampled on that clock, and the block reacts to their edges. At the start of each frame, the first rising edge of the enable loads a fresh word into a shift register, already converted to the line format chosen by a 2-bit mode input. The same event pulses a conversion-start output towards the encoder.

A new bit appears only on a data-clock rising edge seen while the enable is high. The register rotates, so a word can be read out more than once. The enable may drop in the middle of a word for bit-interleaved access, and shifting picks up where it stopped. The output-enable pin follows the enable, so the pad driver can tri-state the line. A protocol error pulse marks a frame start that follows the previous enable rising edge too closely.

Words enter through a valid/ready port with a one-word holding register. `enc_ready` is high while the register is empty, and a word is accepted on any cycle where `enc_valid` and `enc_ready` are both high. The producer must hold `enc_data` steady while `enc_valid` is high and `enc_ready` is low. When a frame starts with the holding register empty, the last accepted word is sent again.

Top module: `pcm_tx_port`

## Requirements
- R1: A frame-start strobe fires on the first `tx_en` rising edge that follows, or coincides with, a `fsync` rising edge. The strobe loads the shift register and raises `conv_start` for exactly one cycle. Later `tx_en` rising edges in the same frame neither load the register nor pulse `conv_start`.
- R2: `sdo` always shows the shift register's most significant bit, so the sign bit (bit 7) is on the line right after the load.
- R3: `sdo_oe` is high exactly while `tx_en` is high, and low otherwise.
- R4: The register shifts one place towards the MSB on each `dclk` rising edge seen while `tx_en` is high. A `dclk` rising edge seen while `tx_en` is low leaves `sdo` unchanged.
- R5: The bit that leaves the MSB re-enters at bit 0. After eight shifts the loaded word is sent again in the same order.
- R6: When `tx_en` falls and later rises within a frame, the next bit sent is the one that followed the last bit sent before the pause.
- R7: With `line_mode` 2'b00 or 2'b11, the loaded word equals the encoder word (bit 7 = sign, 1 = positive; bits 6..0 = magnitude).
- R8: With `line_mode` 2'b01, the sign is kept and bits 6..0 are inverted. If the result is 8'h00, it is replaced by 8'h02.
- R9: With `line_mode` 2'b10, the loaded word is the encoder word XOR 8'h55.
- R10: `proto_err` pulses together with `conv_start` when, since the most recent earlier `tx_en` rising edge, fewer than two `dclk` falling edges have been seen. It stays low otherwise, and also at the first frame after reset.
- R11: `enc_ready` is high after reset and whenever the holding register is empty. It goes low the cycle after a word is accepted and returns high the cycle after a strobe. A strobe with the register empty reloads the last accepted word, formatted with the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| enc_valid | input | 1 | encoder word valid |
| enc_ready | output | 1 | holding register empty |
| enc_data | input | 8 | sign-magnitude word, bit 7 sign (1 positive) |
| line_mode | input | 2 | line format: 00/11 plain, 01 mu-law, 10 A-law |
| dclk | input | 1 | serial data clock level |
| tx_en | input | 1 | data enable level |
| fsync | input | 1 | frame sync level |
| sdo | output | 1 | serial data |
| sdo_oe | output | 1 | drive enable for the serial pad |
| conv_start | output | 1 | one-cycle strobe starting the next conversion |
| proto_err | output | 1 | one-cycle pulse on a too-close frame start |

## Verification
Every input edge is seen at the first system-clock edge after the input changes. The register load, the shift, `conv_start` and `proto_err` all land on that same clock edge. `enc_ready` also changes one edge after the accepting or strobing cycle, and `sdo_oe` follows `tx_en` with no register in between. The bench changes inputs just after a falling system-clock edge and reads outputs at the next falling edge, one whole cycle later. Each result is therefore checked in the first cycle it is due. `conv_start` is checked again one cycle later to show that it has dropped.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

  typedef enum logic [1:0] {
    LM_PLAIN  = 2'b00,
    LM_MU     = 2'b01,
    LM_A      = 2'b10,
    LM_PLAIN2 = 2'b11
  } line_mode_e;

  // Pattern with every even-numbered bit set (bit 0, bit 2, ...).
  function automatic logic [63:0] even_mask(input int width);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < width && i < 64; i++) begin
      if ((i % 2) == 0) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/pcm_tx_edge.sv
module pcm_tx_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~prev_q[g];
    assign fall[g] = ~lvl[g] & prev_q[g];
  end
endmodule

// File: rtl/pcm_tx_format.sv
module pcm_tx_format
  import pcm_tx_pkg::*;
#(
  parameter int         W       = 8,
  parameter logic [W-1:0] ZS_CODE = W'(2)
) (
  input  logic [W-1:0] word_in,
  input  logic [1:0]   mode,
  output logic [W-1:0] word_out
);
  localparam logic [W-1:0] AMASK = W'(even_mask(W));

  logic [W-1:0] mu_raw;
  logic [W-1:0] mu_word;

  assign mu_raw  = {word_in[W-1], ~word_in[W-2:0]};
  assign mu_word = (mu_raw == '0) ? ZS_CODE : mu_raw;

  always_comb begin
    unique case (line_mode_e'(mode))
      LM_MU:   word_out = mu_word;
      LM_A:    word_out = word_in ^ AMASK;
      default: word_out = word_in;
    endcase
  end
endmodule

// File: rtl/pcm_tx_frame.sv
module pcm_tx_frame #(
  parameter int GAP_MIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_rise,
  input  logic fs_rise,
  input  logic dclk_fall,
  output logic strobe,
  output logic strobe_q,
  output logic err_q
);
  localparam int CW = $clog2(GAP_MIN + 1);
  localparam logic [CW-1:0] CMAX = CW'(GAP_MIN);

  logic          armed_q;
  logic          seen_q;
  logic [CW-1:0] falls_q;
  logic          too_close;

  assign strobe    = en_rise & (armed_q | fs_rise);
  assign too_close = seen_q & (falls_q < CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (strobe) begin
      armed_q <= 1'b0;
    end else if (fs_rise) begin
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      falls_q <= '0;
    end else if (en_rise) begin
      seen_q  <= 1'b1;
      falls_q <= '0;
    end else if (dclk_fall && falls_q != CMAX) begin
      falls_q <= falls_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      strobe_q <= strobe;
      err_q    <= strobe & too_close;
    end
  end
endmodule

// File: rtl/pcm_tx_hold.sv
module pcm_tx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         take,
  output logic [W-1:0] held
);
  logic full_q;
  logic accept;

  assign in_ready = ~full_q;
  assign accept   = in_valid & ~full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      held   <= '0;
    end else begin
      if (accept) held <= in_data;
      full_q <= accept | (full_q & ~take);
    end
  end
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         step,
  output logic         msb
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load) begin
      sr_q <= load_word;
    end else if (step) begin
      sr_q <= {sr_q[W-2:0], sr_q[W-1]};
    end
  end

  assign msb = sr_q[W-1];
endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port #(
  parameter int W       = 8,
  parameter int GAP_MIN = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enc_valid,
  output logic         enc_ready,
  input  logic [W-1:0] enc_data,
  input  logic [1:0]   line_mode,
  input  logic         dclk,
  input  logic         tx_en,
  input  logic         fsync,
  output logic         sdo,
  output logic         sdo_oe,
  output logic         conv_start,
  output logic         proto_err
);
  localparam int IDX_DCLK = 0;
  localparam int IDX_EN   = 1;
  localparam int IDX_FS   = 2;
  localparam int NSIG     = 3;

  logic [NSIG-1:0] lvl, rise, fall;
  logic            strobe;
  logic [W-1:0]    held, fmt_word;

  assign lvl[IDX_DCLK] = dclk;
  assign lvl[IDX_EN]   = tx_en;
  assign lvl[IDX_FS]   = fsync;

  pcm_tx_edge #(.N(NSIG)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .fall(fall)
  );

  pcm_tx_frame #(.GAP_MIN(GAP_MIN)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .en_rise(rise[IDX_EN]), .fs_rise(rise[IDX_FS]), .dclk_fall(fall[IDX_DCLK]),
    .strobe(strobe), .strobe_q(conv_start), .err_q(proto_err)
  );

  pcm_tx_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(enc_valid), .in_ready(enc_ready),
    .in_data(enc_data), .take(strobe), .held(held)
  );

  pcm_tx_format #(.W(W)) u_fmt (
    .word_in(held), .mode(line_mode), .word_out(fmt_word)
  );

  pcm_tx_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(strobe), .load_word(fmt_word),
    .step(rise[IDX_DCLK] & tx_en), .msb(sdo)
  );

  assign sdo_oe = tx_en;
endmodule

// File: rtl/pcm_tx_port_chk.sv
module pcm_tx_port_chk (
  input logic clk,
  input logic rst_n,
  input logic enc_valid,
  input logic enc_ready,
  input logic tx_en,
  input logic sdo,
  input logic conv_start,
  input logic proto_err
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R1
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> $stable(sdo)); // R4
  AST_ERR_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> conv_start); // R10
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_valid && enc_ready) |=> !enc_ready); // R11
endmodule

bind pcm_tx_port pcm_tx_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enc_valid(enc_valid), .enc_ready(enc_ready),
  .tx_en(tx_en), .sdo(sdo), .conv_start(conv_start), .proto_err(proto_err)
);

// File: tb/pcm_tx_port_tb_top.sv
module pcm_tx_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enc_valid = 1'b0;
  logic       enc_ready;
  logic [7:0] enc_data = '0;
  logic [1:0] line_mode = 2'b00;
  logic       dclk = 1'b0, tx_en = 1'b0, fsync = 1'b0;
  logic       sdo, sdo_oe, conv_start, proto_err;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [7:0] last_word = '0;

  always #2.5 clk = ~clk;

  pcm_tx_port dut_i (
    .clk(clk), .rst_n(rst_n), .enc_valid(enc_valid), .enc_ready(enc_ready),
    .enc_data(enc_data), .line_mode(line_mode), .dclk(dclk), .tx_en(tx_en),
    .fsync(fsync), .sdo(sdo), .sdo_oe(sdo_oe), .conv_start(conv_start),
    .proto_err(proto_err)
  );

  function automatic logic [7:0] ref_fmt(input logic [7:0] w, input logic [1:0] m);
    logic [7:0] r;
    case (m)
      2'b01: begin
        r = {w[7], ~w[6:0]};
        if (r == 8'h00) r = 8'h02;
      end
      2'b10:   r = w ^ 8'h55;
      default: r = w;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic dtick();
    dclk = 1'b1; step();
    dclk = 1'b0; step();
  endtask

  task automatic push(input logic [7:0] w);
    while (!enc_ready) step();
    enc_valid = 1'b1; enc_data = w; step();
    enc_valid = 1'b0;
    check("R11 ready low after accept", enc_ready, 0);
    last_word = w;
  endtask

  // fsync pulse, then tx_en rise; checks strobe and error flag
  task automatic start_frame(input logic exp_err);
    fsync = 1'b1; step();
    fsync = 1'b0; step();
    tx_en = 1'b1; step();
    check("R1 conv_start pulse", conv_start, 1);
    check("R10 proto_err", proto_err, exp_err);
    check("R11 ready after strobe", enc_ready, 1);
    check("R3 oe high", sdo_oe, 1);
    step();
    check("R1 conv_start one cycle", conv_start, 0);
  endtask

  task automatic read_word(input logic [7:0] e, input int pause_at, input string req);
    for (int i = 0; i < 8; i++) begin
      if (i == pause_at) begin
        tx_en = 1'b0; step();
        check("R3 oe low", sdo_oe, 0);
        dtick();
        check("R4 no shift while disabled", sdo, e[7-i]);
        tx_en = 1'b1; step();
        check("R1 no restrobe", conv_start, 0);
        check("R6 resume", sdo, e[7-i]);
      end
      check(req, sdo, e[7-i]);
      dtick();
    end
  endtask

  task automatic end_frame();
    tx_en = 1'b0; step();
    dtick(); dtick();
  endtask

  initial begin
    logic [7:0] w, e;
    logic [1:0] m;
    void'($urandom(32'd1234));
    repeat (3) step();
    check("R2 reset sdo", sdo, 0);
    check("R11 reset ready", enc_ready, 1);
    check("R1 reset conv_start", conv_start, 0);
    check("R10 reset proto_err", proto_err, 0);
    rst_n = 1'b1; step();

    // R2 / R7: plain, first frame has no error
    push(8'hA6); line_mode = 2'b00;
    start_frame(1'b0);
    read_word(8'hA6, 8, "R2 R7 plain bits");
    read_word(8'hA6, 8, "R5 recirculate");
    end_frame();

    // R8: zero-code suppression (negative full scale)
    push(8'h7F); line_mode = 2'b01;
    start_frame(1'b0);
    read_word(8'h02, 8, "R8 mu zero suppress");
    end_frame();

    // R9 A-law, R6 pause mid-word
    push(8'h80); line_mode = 2'b10;
    start_frame(1'b0);
    read_word(8'hD5, 3, "R9 A-law bits");
    end_frame();

    // R7 mode 11 and R11 stale reuse (no push)
    line_mode = 2'b11;
    start_frame(1'b0);
    read_word(8'h80, 8, "R11 R7 stale word");
    end_frame();

    // R10: frame start too close to previous enable rise
    push(8'h11); line_mode = 2'b00;
    start_frame(1'b0);
    tx_en = 1'b0; step();
    dtick();
    start_frame(1'b1);
    read_word(8'h11, 8, "R10 word after error");
    end_frame();

    // R1: fsync and tx_en rising together
    push(8'h3C);
    fsync = 1'b1; tx_en = 1'b1; step();
    check("R1 coincident strobe", conv_start, 1);
    fsync = 1'b0;
    read_word(8'h3C, 8, "R1 coincident word");
    end_frame();

    // random frames
    for (int f = 0; f < 60; f++) begin
      w = 8'($urandom);
      m = 2'($urandom);
      line_mode = m;
      push(w);
      e = ref_fmt(w, m);
      start_frame(1'b0);
      read_word(e, int'($urandom_range(0, 9)), (m == 2'b01) ? "R8 mu bits" :
                (m == 2'b10) ? "R9 A-law bits" : "R7 plain bits");
      if (f % 4 == 0) read_word(e, 8, "R5 recirculate");
      end_frame();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(150000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule